// File: doc/BRIEF.md
# 64-bit Barrel Shift Unit

This block performs every shift operation of a 64-bit integer datapath on a single shared log shifter. It takes a 64-bit operand, a 5-bit immediate amount, a 64-bit register whose low bits can supply the amount, and a 4-bit operation code. It returns the shifted 64-bit value.

Three shift kinds are available: left logical, right logical and right arithmetic. Each kind comes in five forms:

- word, immediate amount;
- word, register amount;
- doubleword, register amount;
- doubleword, immediate amount;
- doubleword, immediate amount plus 32.

Word forms work on the low 32 bits of the operand and sign-extend the 32-bit result to 64 bits.

With `REG_OUT=1` (the default), the result is registered. It is loaded on each clock edge where `valid_i` is high and is flagged by `valid_o` one cycle later. With `REG_OUT=0`, the path is purely combinational and `valid_o` follows `valid_i`.

Top module: `barrel_shift_unit`

## Requirements
- R1: Every word form (codes 0 to 5) returns a result whose bits 63:32 all equal bit 31 of the 32-bit shifted value.
- R2: Word right shifts act on operand bits 31:0 alone. Code 1 (immediate) and code 4 (register) fill zeros downward from bit 31. Code 2 (immediate) and code 5 (register) fill with operand bit 31. Operand bits 63:32 have no effect.
- R3: Word register-amount forms (codes 3, 4, 5) take the amount from `src_i[4:0]` alone. Code 3 is a left shift.
- R4: Doubleword register-amount forms take the amount from `src_i[5:0]` alone. Code 6 is left, code 7 is right logical and code 8 is right arithmetic.
- R5: Doubleword immediate forms shift by `imm_i` (0 to 31): code 9 is left, 10 is right logical and 11 is right arithmetic. Codes 12, 13 and 14 perform the same three shifts by 32 plus `imm_i` (32 to 63). Code 0 is the word immediate left shift.
- R6: Doubleword right arithmetic shifts fill with operand bit 63. Doubleword right logical shifts fill with zeros.
- R7: Every left shift fills zeros from bit 0 upward.
- R8: Code 0 with `imm_i` = 0 and an all-zero operand yields zero.
- R9: Code 15 yields zero whatever the other inputs are.
- R10: With `REG_OUT=1`:
  - reset clears `result_o` and `valid_o`;
  - a result appears, with `valid_o` high, one clock after it is presented with `valid_i` high;
  - while `valid_i` is low, `result_o` holds and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Inputs carry an operation this cycle |
| op_i | input | 4 | Operation code (see R1 to R9) |
| operand_i | input | 64 | Value to be shifted |
| imm_i | input | 5 | Immediate shift amount |
| src_i | input | 64 | Register supplying the variable shift amount |
| result_o | output | 64 | Shifted value |
| valid_o | output | 1 | `result_o` carries a new result |

## Verification
A wrong stage select or fill bit inside the shared shifter shows up in `result_o` on the very next clock after the operation is presented. It appears as a single bit lane or a fill region that is wrong for only some shift amounts. For that reason, every form is driven across the full amount range, including 0, 31, 32 and 63, against a model built from plain language operators.

A wrong mode decode shows instead as an entire class of operations with the wrong direction, width or offset. Stray amount bits show up when `src_i` carries junk above the used field. A broken output register shows as a result that moves while `valid_i` is low.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int unsigned DW  = 64;
  localparam int unsigned AW  = $clog2(DW);
  localparam int unsigned WW  = DW / 2;

  typedef enum logic [3:0] {
    OP_SLL_WI = 4'd0,
    OP_SRL_WI = 4'd1,
    OP_SRA_WI = 4'd2,
    OP_SLL_WV = 4'd3,
    OP_SRL_WV = 4'd4,
    OP_SRA_WV = 4'd5,
    OP_SLL_DV = 4'd6,
    OP_SRL_DV = 4'd7,
    OP_SRA_DV = 4'd8,
    OP_SLL_DI = 4'd9,
    OP_SRL_DI = 4'd10,
    OP_SRA_DI = 4'd11,
    OP_SLL_DH = 4'd12,
    OP_SRL_DH = 4'd13,
    OP_SRA_DH = 4'd14,
    OP_NONE   = 4'd15
  } shop_e;

  typedef struct packed {
    logic          legal;
    logic          left;
    logic          arith;
    logic          word;
    logic [AW-1:0] amt;
  } shctl_t;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [AW-2:0] imm_i,
  input  logic [AW-1:0] src_amt_i,
  output shctl_t        ctl_o
);
  shop_e op;
  assign op = shop_e'(op_i);

  logic [AW-1:0] amt_wv, amt_dv, amt_di, amt_dh;
  assign amt_wv = {1'b0, src_amt_i[AW-2:0]};  // word: low 5 bits only
  assign amt_dv = src_amt_i;
  assign amt_di = {1'b0, imm_i};
  assign amt_dh = {1'b1, imm_i};              // +32

  always_comb begin
    ctl_o = '0;
    ctl_o.legal = 1'b1;
    unique case (op)
      OP_SLL_WI: begin ctl_o.left = 1'b1; ctl_o.word = 1'b1; ctl_o.amt = amt_di; end
      OP_SRL_WI: begin ctl_o.word = 1'b1; ctl_o.amt = amt_di; end
      OP_SRA_WI: begin ctl_o.word = 1'b1; ctl_o.arith = 1'b1; ctl_o.amt = amt_di; end
      OP_SLL_WV: begin ctl_o.left = 1'b1; ctl_o.word = 1'b1; ctl_o.amt = amt_wv; end
      OP_SRL_WV: begin ctl_o.word = 1'b1; ctl_o.amt = amt_wv; end
      OP_SRA_WV: begin ctl_o.word = 1'b1; ctl_o.arith = 1'b1; ctl_o.amt = amt_wv; end
      OP_SLL_DV: begin ctl_o.left = 1'b1; ctl_o.amt = amt_dv; end
      OP_SRL_DV: begin ctl_o.amt = amt_dv; end
      OP_SRA_DV: begin ctl_o.arith = 1'b1; ctl_o.amt = amt_dv; end
      OP_SLL_DI: begin ctl_o.left = 1'b1; ctl_o.amt = amt_di; end
      OP_SRL_DI: begin ctl_o.amt = amt_di; end
      OP_SRA_DI: begin ctl_o.arith = 1'b1; ctl_o.amt = amt_di; end
      OP_SLL_DH: begin ctl_o.left = 1'b1; ctl_o.amt = amt_dh; end
      OP_SRL_DH: begin ctl_o.amt = amt_dh; end
      OP_SRA_DH: begin ctl_o.arith = 1'b1; ctl_o.amt = amt_dh; end
      default:   ctl_o.legal = 1'b0;
    endcase
  end

  always_comb begin
    if (ctl_o.word) assert (!ctl_o.amt[AW-1]) else $error("AST_WORD_AMT_RANGE");  // R3
  end
endmodule

// File: rtl/bsu_prep.sv
module bsu_prep
  import bsu_pkg::*;
(
  input  logic [DW-1:0] operand_i,
  input  shctl_t        ctl_i,
  output logic [DW-1:0] core_o,
  output logic          fill_o
);
  logic          sign_bit;
  logic          fill_r;
  logic [DW-1:0] widened;
  logic [DW-1:0] flipped;

  assign sign_bit = ctl_i.word ? operand_i[WW-1] : operand_i[DW-1];
  assign fill_r   = ctl_i.arith & sign_bit;
  // word forms: upper half replaced by fill so right shifts pull in the right bits
  assign widened  = ctl_i.word ? {{WW{fill_r}}, operand_i[WW-1:0]} : operand_i;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign flipped[i] = widened[DW-1-i];
  end

  assign core_o = ctl_i.left ? flipped : widened;
  assign fill_o = ctl_i.left ? 1'b0 : fill_r;
endmodule

// File: rtl/bsu_core.sv
module bsu_core
  import bsu_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          fill_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] lvl [AW+1];

  assign lvl[0] = data_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign lvl[s+1] = amt_i[s] ? {{D{fill_i}}, lvl[s][DW-1:D]} : lvl[s];
  end

  assign data_o = lvl[AW];

  always_comb begin
    if (amt_i == '0) assert (data_o == data_i) else $error("AST_ZERO_AMT_PASS");  // R5
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] operand_i,
  input  logic [AW-2:0] imm_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] result_o,
  output logic          valid_o
);
  shctl_t        ctl;
  logic [DW-1:0] core_in, core_out, unflip, shaped, res_d;
  logic          fill;
  logic          src_unused;

  assign src_unused = ^src_i[DW-1:AW];

  bsu_decode u_decode (
    .op_i      (op_i),
    .imm_i     (imm_i),
    .src_amt_i (src_i[AW-1:0]),
    .ctl_o     (ctl)
  );

  bsu_prep u_prep (
    .operand_i (operand_i),
    .ctl_i     (ctl),
    .core_o    (core_in),
    .fill_o    (fill)
  );

  bsu_core u_core (
    .data_i (core_in),
    .amt_i  (ctl.amt),
    .fill_i (fill),
    .data_o (core_out)
  );

  for (genvar i = 0; i < DW; i++) begin : g_unrev
    assign unflip[i] = ctl.left ? core_out[DW-1-i] : core_out[i];
  end

  assign shaped = ctl.word ? {{WW{unflip[WW-1]}}, unflip[WW-1:0]} : unflip;
  assign res_d  = ctl.legal ? shaped : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o <= '0;
        valid_o  <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) result_o <= res_d;
      end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);  // R10
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o) && !valid_o);  // R10
  end else begin : g_comb
    assign result_o = res_d;
    assign valid_o  = valid_i;
  end

  AST_WORD_SRL_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRL_WV && src_i[AW-2:0] != '0) |-> res_d[WW-1] == 1'b0);  // R2
  AST_WORD_SRA_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRA_WV) |-> res_d[DW-1] == operand_i[WW-1]);  // R1
  AST_DWORD_SRA_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRA_DV || op_i == OP_SRA_DH) |-> res_d[DW-1] == operand_i[DW-1]);  // R6
  AST_DWORD_SRL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRL_DH) |-> res_d[DW-1:WW] == '0);  // R5
  AST_LEFT_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SLL_DV && src_i[AW-1:0] != '0) |-> res_d[0] == 1'b0);  // R7
  AST_NOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SLL_WI && imm_i == '0 && operand_i == '0) |-> res_d == '0);  // R8
  AST_UNUSED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE) |-> res_d == '0);  // R9
endmodule

// File: tb/barrel_shift_unit_test.sv
module barrel_shift_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [63:0] operand_i = '0;
  logic [4:0]  imm_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  barrel_shift_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .imm_i(imm_i), .src_i(src_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                        input logic [4:0] imm, input logic [63:0] src);
    logic [31:0] w, r32;
    int          n;
    logic [63:0] r;
    w = a[31:0];
    r = '0;
    if (op <= 4'd5) begin
      n = (op <= 4'd2) ? int'(imm) : int'(src[4:0]);
      case (op % 3)
        0:       r32 = w << n;
        1:       r32 = w >> n;
        default: r32 = $unsigned($signed(w) >>> n);
      endcase
      r = {{32{r32[31]}}, r32};
    end else if (op <= 4'd14) begin
      if (op <= 4'd8)       n = int'(src[5:0]);
      else if (op <= 4'd11) n = int'(imm);
      else                  n = 32 + int'(imm);
      case (op % 3)
        0:       r = a << n;
        1:       r = a >>> n;
        default: r = $unsigned($signed(a) >>> n);
      endcase
      if (op % 3 == 1) r = a >> n;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [63:0] a,
                        input logic [4:0] imm, input logic [63:0] src);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; operand_i = a; imm_i = imm; src_i = src;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, result_o, model(op, a, imm, src));
    check(req, {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_reset();
    #3;
    check("R10 reset result", result_o, 64'd0);
    check("R10 reset valid", {63'd0, valid_o}, 64'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_word_forms();
    run_op("R1 sll word sign", 4'd0, 64'h0000_0000_0000_0001, 5'd31, '0);
    check("R1 upper ones", result_o, 64'hFFFF_FFFF_8000_0000);
    run_op("R2 srl word zero fill", 4'd1, 64'hDEAD_BEEF_8000_0000, 5'd4, '0);
    check("R2 srl value", result_o, 64'h0000_0000_0800_0000);
    run_op("R2 sra word sign fill", 4'd2, 64'h0000_0000_8000_0000, 5'd31, '0);
    check("R2 sra value", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R2 upper ignored", 4'd4, 64'hFFFF_FFFF_0000_00F0, 5'd0, 64'd4);
    check("R2 srlv value", result_o, 64'h0000_0000_0000_000F);
    run_op("R3 src mask", 4'd3, 64'h1, 5'd0, 64'hFFFF_FFFF_FFFF_FFE1);
    check("R3 sllv by 1", result_o, 64'h2);
    run_op("R3 srav", 4'd5, 64'h0000_0000_F000_0000, 5'd0, 64'h20 | 64'd28);
    check("R3 srav by 28", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_dword_var();
    run_op("R4 dsllv 63", 4'd6, 64'h3, 5'd0, 64'hFFFF_FFC0 | 64'd63);
    check("R4 dsllv value", result_o, 64'h8000_0000_0000_0000);
    run_op("R6 dsrav fill", 4'd8, 64'h8000_0000_0000_0000, 5'd0, 64'd63);
    check("R6 dsrav value", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R6 dsrlv zero", 4'd7, 64'h8000_0000_0000_0000, 5'd0, 64'hC0 | 64'd32);
    check("R6 dsrlv value", result_o, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_dword_imm();
    run_op("R5 dsll imm", 4'd9, 64'h1, 5'd31, '0);
    check("R5 dsll value", result_o, 64'h0000_0000_8000_0000);
    run_op("R5 dsll32 0", 4'd12, 64'h1, 5'd0, '0);
    check("R5 dsll32 value", result_o, 64'h0000_0001_0000_0000);
    run_op("R5 dsrl32 31", 4'd13, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, '0);
    check("R5 dsrl32 value", result_o, 64'h1);
    run_op("R6 dsra32", 4'd14, 64'h8000_0000_0000_0000, 5'd0, '0);
    check("R6 dsra32 value", result_o, 64'hFFFF_FFFF_8000_0000);
    run_op("R7 left zero fill", 4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 5'd8, '0);
    check("R7 low byte", result_o, 64'hFFFF_FFFF_FFFF_FF00);
  endtask

  task automatic t_nop_unused();
    run_op("R8 nop", 4'd0, 64'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 nop value", result_o, 64'd0);
    run_op("R9 unused code", 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 64'd5);
    check("R9 value", result_o, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    run_op("R10 load", 4'd7, 64'h1234_5678_9ABC_DEF0, 5'd0, 64'd4);
    prev = result_o;
    @(negedge clk_i);
    op_i = 4'd6; operand_i = 64'hFFFF; src_i = 64'd9;
    @(negedge clk_i);
    check("R10 hold result", result_o, prev);
    check("R10 idle valid", {63'd0, valid_o}, 64'd0);
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 16; op++) begin
      for (int n = 0; n < 64; n++) begin
        logic [63:0] a, s;
        a = {$urandom(), $urandom()};
        s = {$urandom(), $urandom()};
        s[5:0] = n[5:0];
        run_op($sformatf("R1 R4 R5 R6 sweep op %0d amt %0d", op, n),
               op[3:0], a, n[4:0], s);
      end
    end
  endtask

  initial begin
    t_reset();
    t_word_forms();
    t_dword_var();
    t_dword_imm();
    t_nop_unused();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule